// File: doc/BRIEF.md
# Frame Metadata Stamper With Missed-Frame Detection

This block sits at the end of a camera pixel pipeline and writes identifying metadata into every frame it forwards. It keeps a free-running clock-cycle timestamp, a count of frames that have started and a count of trigger events. At each frame start it takes a snapshot of all three values. It then replaces the first twelve bytes of the frame's first line with that snapshot. The stream is never stalled: each input beat leaves the block exactly one cycle later.

The block also checks that every trigger produced a frame. When a frame starts while more than one trigger is still waiting for a frame, a sticky missed-frame flag is raised. The flag stays set until software-side logic asks for a clear. A clear request zeroes the counters and the flag together at the next frame boundary, so a frame never carries a mix of old and new counts. The trigger pin is asynchronous to the pixel clock and is synchronised inside the block.

Top module: `frame_stamper`

## Requirements
- R1: The timestamp is 32 bits wide. It is 0 after reset and advances by one every clock cycle. The value stamped into a frame is the timestamp value present in the cycle of that frame's start beat.
- R2: Every output beat copies the valid, start-of-frame and end-of-line markers of the input beat accepted one clock earlier. The input is never stalled. After reset, out_valid and miss_flag are 0.
- R3: In line 0 of a frame, output bytes 0 to 3 hold the timestamp, least significant byte first. Byte 0 is the start-of-frame beat, and bytes are counted over valid beats only.
- R4: Output bytes 4 to 7 of line 0 hold the frame count, least significant byte first. The count includes the current frame, so the first frame after reset carries 1.
- R5: Output bytes 8 to 11 of line 0 hold the trigger count, least significant byte first. A trigger is counted if its rising edge comes at least 4 clock cycles before the frame start.
- R6: Pixels of line 0 after byte 11, and all pixels of later lines, leave the block unchanged.
- R7: At a frame start, miss_flag is set when the trigger count exceeds the count of frames started before this one by more than one. Once set, it stays set until a clear takes effect.
- R8: A pulse on clr_req takes effect at the next start-of-frame beat, or at that beat itself if the pulse coincides with it. That frame is stamped with timestamp 0, frame count 1 and trigger count 0, miss_flag returns to 0, and the timestamp reads 1 in the following cycle.
- R9: If line 0 ends before 12 beats, the stamp is cut short at the end of that line. The following line passes through unchanged.
- R10: The trigger count advances once per rising edge of trig_in. A trigger held high for many cycles counts as one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat carries a pixel |
| in_sof | input | 1 | Input beat is the first pixel of a frame |
| in_eol | input | 1 | Input beat is the last pixel of a line |
| in_pix | input | 8 | Input pixel |
| trig_in | input | 1 | Asynchronous trigger, counted on rising edges |
| clr_req | input | 1 | Request to clear counters and flag at the next frame start |
| out_valid | output | 1 | Output beat carries a pixel |
| out_sof | output | 1 | Output frame-start marker |
| out_eol | output | 1 | Output end-of-line marker |
| out_pix | output | 8 | Output pixel, stamped or passed through |
| miss_flag | output | 1 | Sticky missed-frame indication |

## Verification
A wrong counter value shows up in the stamp bytes of the very next frame. Each such byte is compared with a behavioural model, so a timestamp that skips or stalls, or a frame or trigger count that is off by one, is caught within one frame. A wrong byte-index or line-0 state corrupts either the stamp or the pass-through pixels in the same cycle. A flag that fails to set or to hold differs from the model one cycle after the frame start that should have changed it. A clear applied at the wrong boundary leaves nonzero stamps in the frame that should carry 0, 1 and 0.

// File: rtl/fs_pkg.sv
package fs_pkg;

    localparam int PIX_W       = 8;
    localparam int CNT_W       = 32;
    localparam int STAMP_WORDS = 3;
    localparam int STAMP_BYTES = STAMP_WORDS * CNT_W / PIX_W;
    localparam int IDX_W       = $clog2(STAMP_BYTES + 1);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [PIX_W-1:0] pix_t;

    // Packed with the timestamp in the low bits: byte k of the flat vector
    // is stamp byte k on the wire.
    typedef struct packed {
        cnt_t trig;
        cnt_t frame;
        cnt_t ts;
    } stamp_t;

    typedef struct packed {
        logic valid;
        logic sof;
        logic eol;
        pix_t pix;
    } beat_t;

    localparam idx_t STAMP_LAST = idx_t'(STAMP_BYTES);

    function automatic pix_t stamp_byte(input stamp_t s, input idx_t idx);
        logic [$bits(stamp_t)-1:0] flat;
        flat = s;
        return flat[idx*PIX_W +: PIX_W];
    endfunction

endpackage

// File: rtl/fs_trig_sync.sv
module fs_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_async,
    output logic trig_pulse
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], trig_async};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign trig_pulse = sync_q[STAGES-1] & ~prev_q;

    // R10: a rising edge yields a single-cycle pulse
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);

endmodule

// File: rtl/fs_counters.sv
module fs_counters
    import fs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sof_fire,
    input  logic   trig_pulse,
    input  logic   clr_req,
    output stamp_t snap_now,
    output stamp_t snap_q,
    output logic   miss_flag
);

    cnt_t ts_q, frame_q, trig_q;
    logic pend_q, miss_q;
    logic clr_eff;
    logic miss_hit;
    logic [CNT_W:0] trig_wide, lim_wide;

    assign clr_eff   = pend_q | clr_req;
    assign trig_wide = {1'b0, trig_q};
    assign lim_wide  = {1'b0, frame_q} + (CNT_W+1)'(1);
    assign miss_hit  = trig_wide > lim_wide;

    always_comb begin
        if (clr_eff) begin
            snap_now.ts    = '0;
            snap_now.frame = cnt_t'(1);
            snap_now.trig  = '0;
        end else begin
            snap_now.ts    = ts_q;
            snap_now.frame = frame_q + cnt_t'(1);
            snap_now.trig  = trig_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q    <= '0;
            frame_q <= '0;
            trig_q  <= '0;
            pend_q  <= 1'b0;
            miss_q  <= 1'b0;
            snap_q  <= '0;
        end else begin
            if (sof_fire && clr_eff) begin
                ts_q    <= cnt_t'(1);
                frame_q <= cnt_t'(1);
                trig_q  <= cnt_t'(trig_pulse);
                pend_q  <= 1'b0;
                miss_q  <= 1'b0;
            end else begin
                ts_q <= ts_q + cnt_t'(1);
                if (sof_fire) frame_q <= frame_q + cnt_t'(1);
                if (trig_pulse) trig_q <= trig_q + cnt_t'(1);
                if (sof_fire && miss_hit) miss_q <= 1'b1;
                if (clr_req) pend_q <= 1'b1;
            end
            if (sof_fire) snap_q <= snap_now;
        end
    end

    assign miss_flag = miss_q;

    p_ts_step_r1: assert property (@(posedge clk) disable iff (rst)
        !(sof_fire && clr_eff) |=> ts_q == $past(ts_q) + cnt_t'(1));

    p_frame_step_r4: assert property (@(posedge clk) disable iff (rst)
        (sof_fire && !clr_eff) |=> frame_q == $past(frame_q) + cnt_t'(1));

    p_trig_step_r10: assert property (@(posedge clk) disable iff (rst)
        !(sof_fire && clr_eff) |=>
            (trig_q == $past(trig_q) || trig_q == $past(trig_q) + cnt_t'(1)));

    p_miss_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (miss_q && !(sof_fire && clr_eff)) |=> miss_q);

    p_clear_apply_r8: assert property (@(posedge clk) disable iff (rst)
        (sof_fire && clr_eff) |=> (!miss_q && frame_q == cnt_t'(1) && !pend_q));

endmodule

// File: rtl/fs_inserter.sv
module fs_inserter
    import fs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  beat_t  in_b,
    input  stamp_t snap_now,
    input  stamp_t snap_q,
    output beat_t  out_b
);

    logic   line0_q;
    idx_t   idx_q;
    logic   sof_fire;
    logic   in_line0;
    idx_t   cur_idx;
    logic   stamping;
    stamp_t src;
    pix_t   pix_sel;

    assign sof_fire = in_b.valid & in_b.sof;
    assign in_line0 = sof_fire | line0_q;
    assign cur_idx  = sof_fire ? '0 : idx_q;
    assign stamping = in_b.valid && in_line0 && (cur_idx < STAMP_LAST);
    assign src      = sof_fire ? snap_now : snap_q;
    assign pix_sel  = stamping ? stamp_byte(src, cur_idx) : in_b.pix;

    always_ff @(posedge clk) begin
        if (rst) begin
            line0_q <= 1'b0;
            idx_q   <= '0;
            out_b   <= '0;
        end else begin
            if (in_b.valid) begin
                if (in_b.sof) begin
                    line0_q <= ~in_b.eol;
                    idx_q   <= idx_t'(1);
                end else if (line0_q) begin
                    if (in_b.eol) line0_q <= 1'b0;
                    if (idx_q < STAMP_LAST) idx_q <= idx_q + idx_t'(1);
                end
            end
            out_b.valid <= in_b.valid;
            out_b.sof   <= sof_fire;
            out_b.eol   <= in_b.valid & in_b.eol;
            out_b.pix   <= pix_sel;
        end
    end

    p_valid_fwd_r2: assert property (@(posedge clk) disable iff (rst)
        in_b.valid |=> out_b.valid);

    p_idle_fwd_r2: assert property (@(posedge clk) disable iff (rst)
        !in_b.valid |=> (!out_b.valid && !out_b.sof && !out_b.eol));

    p_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (in_b.valid && !in_line0) |=> out_b.pix == $past(in_b.pix));

    p_idx_bound_r9: assert property (@(posedge clk) disable iff (rst)
        idx_q <= STAMP_LAST);

endmodule

// File: rtl/frame_stamper.sv
module frame_stamper
    import fs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eol,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             trig_in,
    input  logic             clr_req,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eol,
    output logic [PIX_W-1:0] out_pix,
    output logic             miss_flag
);

    beat_t  in_b, out_b;
    stamp_t snap_now, snap_q;
    logic   trig_pulse;
    logic   sof_fire;

    assign in_b.valid = in_valid;
    assign in_b.sof   = in_sof;
    assign in_b.eol   = in_eol;
    assign in_b.pix   = in_pix;
    assign sof_fire   = in_valid & in_sof;

    fs_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .trig_async (trig_in),
        .trig_pulse (trig_pulse)
    );

    fs_counters u_cnt (
        .clk        (clk),
        .rst        (rst),
        .sof_fire   (sof_fire),
        .trig_pulse (trig_pulse),
        .clr_req    (clr_req),
        .snap_now   (snap_now),
        .snap_q     (snap_q),
        .miss_flag  (miss_flag)
    );

    fs_inserter u_ins (
        .clk      (clk),
        .rst      (rst),
        .in_b     (in_b),
        .snap_now (snap_now),
        .snap_q   (snap_q),
        .out_b    (out_b)
    );

    assign out_valid = out_b.valid;
    assign out_sof   = out_b.sof;
    assign out_eol   = out_b.eol;
    assign out_pix   = out_b.pix;

endmodule

// File: tb/frame_stamper_bench.sv
`timescale 1ns/1ps
module frame_stamper_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [7:0] in_pix = 8'h00;
    logic       trig_in = 1'b0, clr_req = 1'b0;
    logic       out_valid, out_sof, out_eol, miss_flag;
    logic [7:0] out_pix;

    always #5 clk = ~clk;

    frame_stamper u_frame_stamper (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .in_pix(in_pix), .trig_in(trig_in),
        .clr_req(clr_req), .out_valid(out_valid), .out_sof(out_sof),
        .out_eol(out_eol), .out_pix(out_pix), .miss_flag(miss_flag)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit chk_en = 0;
    int trig_issued = 0;
    string scen_tag = "";

    // behavioural reference state
    bit [31:0] ts_m, fr_m, sn_ts, sn_fr, sn_tr;
    int  trig_base;
    bit  miss_m, pend_m, line0_m;
    int  idx_m;
    bit  e_valid, e_sof, e_eol, e_miss;
    bit [7:0] e_pix;
    string e_tag;

    function automatic bit [7:0] pick(bit [31:0] w, int b);
        return 8'((w >> (8*b)) & 32'hFF);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ts_m = 0; fr_m = 0; trig_base = trig_issued; miss_m = 0; pend_m = 0;
            line0_m = 0; idx_m = 0;
            e_valid = 0; e_sof = 0; e_eol = 0; e_miss = 0; e_pix = 0; e_tag = "R2";
        end else begin
            bit [31:0] tr_now;
            tr_now  = 32'(trig_issued - trig_base);
            e_valid = in_valid;
            e_sof   = in_valid && in_sof;
            e_eol   = in_valid && in_eol;
            e_pix   = in_pix;
            e_tag   = "R6";
            if (in_valid && in_sof) begin
                if (pend_m || clr_req) begin
                    sn_ts = 0; sn_fr = 1; sn_tr = 0;
                    ts_m = 1; fr_m = 1; trig_base = trig_issued;
                    miss_m = 0; pend_m = 0;
                end else begin
                    if (longint'(tr_now) > longint'(fr_m) + 1) miss_m = 1;
                    sn_ts = ts_m; sn_fr = fr_m + 1; sn_tr = tr_now;
                    fr_m = fr_m + 1; ts_m = ts_m + 1;
                end
                line0_m = 1; idx_m = 0;
            end else begin
                ts_m = ts_m + 1;
                if (clr_req) pend_m = 1;
            end
            if (in_valid && line0_m) begin
                if (idx_m < 12) begin
                    if (idx_m < 4)      begin e_pix = pick(sn_ts, idx_m);     e_tag = "R1 R3"; end
                    else if (idx_m < 8) begin e_pix = pick(sn_fr, idx_m - 4); e_tag = "R4"; end
                    else                begin e_pix = pick(sn_tr, idx_m - 8); e_tag = "R5 R10"; end
                    if (scen_tag != "") e_tag = {scen_tag, " ", e_tag};
                    idx_m++;
                end
                if (in_eol) line0_m = 0;
            end
            e_miss = miss_m;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            checks++;
            if (out_valid !== e_valid || out_sof !== e_sof || out_eol !== e_eol) begin
                errors++;
                $display("FAIL R2 markers: got v%0b s%0b e%0b expected v%0b s%0b e%0b",
                         out_valid, out_sof, out_eol, e_valid, e_sof, e_eol);
            end
            checks++;
            if (miss_flag !== e_miss) begin
                errors++;
                $display("FAIL R7 R8 miss_flag: got %0b expected %0b", miss_flag, e_miss);
            end
            if (e_valid) begin
                checks++;
                if (out_pix !== e_pix) begin
                    errors++;
                    $display("FAIL %s pixel: got %02h expected %02h", e_tag, out_pix, e_pix);
                end
            end
        end
    end

    task automatic beat(bit v, bit s, bit e, bit [7:0] p);
        @(negedge clk);
        in_valid = v; in_sof = s; in_eol = e; in_pix = p;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) beat(0, 0, 0, 8'h00);
    endtask

    task automatic frame(int len0, int nlines, int len, int seed, bit clr_at_sof);
        for (int l = 0; l < nlines; l++) begin
            int w;
            w = (l == 0) ? len0 : len;
            for (int c = 0; c < w; c++) begin
                if (c % 5 == 3) beat(0, 0, 0, 8'h00);
                beat(1, (l == 0 && c == 0), (c == w - 1), 8'(seed + l*37 + c*5));
                clr_req = (clr_at_sof && l == 0 && c == 0);
            end
        end
        beat(0, 0, 0, 8'h00);
        clr_req = 0;
        idle(3);
    endtask

    // trigger: held for hold cycles, then time for the synchroniser to settle
    task automatic trigger(int hold);
        @(negedge clk); trig_in = 1;
        repeat (hold) @(negedge clk);
        trig_in = 0;
        repeat (6) @(negedge clk);
        trig_issued++;
    endtask

    task automatic clear_pulse();
        @(negedge clk); clr_req = 1;
        @(negedge clk); clr_req = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_en = 1;           // reset state (R2, R7) is compared here
        repeat (2) @(negedge clk);
        rst = 0;
        idle(4);
        // normal operation: one trigger per frame
        trigger(1);  frame(16, 3, 8, 8'h10, 0);
        trigger(2);  frame(20, 2, 6, 8'h51, 0);
        // R10: long trigger hold counts once
        trigger(30); frame(14, 2, 5, 8'h22, 0);
        // R7: two extra triggers with no frame -> missed
        trigger(1); trigger(1); trigger(1);
        frame(13, 2, 4, 8'h77, 0);
        // R7: flag stays set on a good frame and a frame without trigger
        trigger(1);  frame(16, 2, 4, 8'h03, 0);
        frame(12, 2, 4, 8'hA0, 0);
        // R8: clear between frames, trigger before the boundary is discarded
        scen_tag = "R8";
        clear_pulse(); idle(5); trigger(1);
        frame(16, 2, 6, 8'h44, 0);
        scen_tag = "";
        trigger(1);  frame(16, 2, 6, 8'h45, 0);
        // R9: short first lines
        scen_tag = "R9";
        trigger(1);  frame(5, 3, 7, 8'h90, 0);
        trigger(1);  frame(1, 2, 3, 8'h91, 0);
        scen_tag = "";
        // R7 again then R8: clear coinciding with the frame start
        trigger(1); trigger(1); trigger(1);
        frame(12, 1, 4, 8'h31, 0);
        scen_tag = "R8";
        trigger(1);  frame(16, 2, 4, 8'h32, 1);
        scen_tag = "";
        trigger(1);  frame(16, 2, 4, 8'h33, 0);
        idle(10);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule